// File: doc/BRIEF.md
# Carry-Skip Adder

This block adds two unsigned or two's complement words together with a single carry bit. It returns a word-wide sum and the carry that leaves the most significant position. The logic is purely combinational. The word is cut into equal groups of bits. Each bit first forms its generate and propagate terms, and all bits do this in parallel. Inside a group, the carry ripples upward through a chain of carry/sum cells.

Each group also has a skip path. When every propagate term in a group is set, the group's incoming carry is known to reach its top unchanged. A 2:1 selector then forwards that carry directly to the next group, and the ripple chain is left out of the path. The worst-case carry path then crosses one ripple chain at each end of the word, plus one selector for each group in between. A full ripple through every bit is avoided.

The word width and the group width are parameters, and the group width must divide the word width. The defaults are a 16-bit word in four 4-bit groups. Subtraction is done by the user: feed the complement of the subtrahend and set the carry input.

Top module: `carry_skip_adder`

## Requirements
- R1: For every input combination, {cout, sum} equals the (WIDTH+1)-bit value a + b + cin.
- R2: cout is the carry leaving bit WIDTH-1. For example, 0xFFFF + 0x0001 with cin=0 gives sum 0x0000 and cout 1, and 0x7FFF + 0x0001 gives sum 0x8000 and cout 0.
- R3: When a ^ b is all ones, the result is decided by cin alone. With cin=0 the sum is all ones and cout is 0. With cin=1 the sum is all zeros and cout is 1.
- R4: When all GRP propagate bits of a group are 1, that group's carry-out equals its carry-in. The carry is taken through the skip selector.
- R5: When any propagate bit of a group is 0, that group's carry-out equals the carry rippled out of its top cell.
- R6: Group 0 takes cin. Each later group takes the carry-out of the group below it, so a carry formed in the lowest group can travel to cout through every group above it.
- R7: Feeding a and ~b with cin=1 gives sum = (a - b) mod 2^WIDTH. cout is 1 exactly when a >= b as unsigned values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | WIDTH | First operand |
| b | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top bit |

## Verification
The assertions assume that a, b and cin are settled, known values whenever the combinational outputs are examined. They also assume that GRP divides WIDTH. The bench changes all three inputs together on the falling edge of its clock, never holds an X on them, and reads the result a nanosecond after the rising edge. The stimulus covers words whose propagate bits are all set, words where only chosen groups are fully propagating, subtraction operands, and random words. Together these drive both the skip and the ripple branch of every group.

// File: rtl/csa_pkg.sv
`timescale 1ns/1ps
// Package: shared defaults and helpers for the carry-skip adder.
// Assumes: nothing beyond a standard elaboration environment.
package csa_pkg;
    // Default word width and skip group width.
    localparam int unsigned CSA_WIDTH_DEF = 16;
    localparam int unsigned CSA_GRP_DEF   = 4;

    // Per-bit carry terms, kept together where a cell consumes both.
    typedef struct packed {
        logic gen;
        logic prop;
    } csa_pg_t;

    // Number of skip groups for a given word and group width.
    function automatic int unsigned csa_groups(input int unsigned w, input int unsigned m);
        return w / m;
    endfunction
endpackage

// File: rtl/csa_pg_gen.sv
`timescale 1ns/1ps
// Module: csa_pg_gen
// Forms generate (a AND b) and propagate (a XOR b) for every bit at once.
// Assumes: operands are stable; no ordering between bits.
module csa_pg_gen #(
    parameter int unsigned WIDTH = csa_pkg::CSA_WIDTH_DEF
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            // One bit's generate and propagate terms.
            always_comb begin
                gen[i]  = op_a[i] & op_b[i];
                prop[i] = op_a[i] ^ op_b[i];
            end
        end
    endgenerate
endmodule

// File: rtl/csa_cs_cell.sv
`timescale 1ns/1ps
// Module: csa_cs_cell
// A single carry/sum cell: sum = p ^ c_in, c_out = g | (p & c_in).
// Assumes: p and g come from the same operand bit.
module csa_cs_cell (
    input  csa_pkg::csa_pg_t pg,
    input  logic             c_in,
    output logic             s,
    output logic             c_out
);
    // Sum and carry of one bit position.
    always_comb begin
        s     = pg.prop ^ c_in;
        c_out = pg.gen | (pg.prop & c_in);
    end
endmodule

// File: rtl/csa_group.sv
`timescale 1ns/1ps
// Module: csa_group
// A GRP-bit ripple chain whose carry-out is chosen by a 2:1 selector:
// the group carry-in when every propagate bit is set, else the rippled carry.
// Assumes: GRP >= 1; gen/prop are ordered LSB first.
module csa_group #(
    parameter int unsigned GRP = csa_pkg::CSA_GRP_DEF
) (
    input  logic [GRP-1:0] gen,
    input  logic [GRP-1:0] prop,
    input  logic           c_in,
    output logic [GRP-1:0] s,
    output logic           c_ripple,
    output logic           skip,
    output logic           c_out
);
    logic [GRP:0] chain;

    // The chain starts at the group carry-in.
    always_comb chain[0] = c_in;

    genvar i;
    generate
        for (i = 0; i < GRP; i++) begin : g_cell
            csa_pkg::csa_pg_t pg_i;
            // Pack this bit's terms for the cell.
            always_comb pg_i = '{gen: gen[i], prop: prop[i]};
            csa_cs_cell u_cell (
                .pg    (pg_i),
                .c_in  (chain[i]),
                .s     (s[i]),
                .c_out (chain[i+1])
            );
        end
    endgenerate

    // Skip condition and the carry selector.
    always_comb begin
        c_ripple = chain[GRP];
        skip     = &prop;
        c_out    = skip ? c_in : c_ripple;
    end
endmodule

// File: rtl/carry_skip_adder.sv
`timescale 1ns/1ps
// Module: carry_skip_adder (top)
// Combinational WIDTH-bit adder made of WIDTH/GRP ripple groups, each with
// a skip selector; group carries are chained from cin to cout.
// Assumes: GRP divides WIDTH; inputs are known values.
module carry_skip_adder #(
    parameter int unsigned WIDTH = csa_pkg::CSA_WIDTH_DEF,
    parameter int unsigned GRP   = csa_pkg::CSA_GRP_DEF
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    localparam int unsigned NGRP = csa_pkg::csa_groups(WIDTH, GRP);

    logic [WIDTH-1:0] gen;
    logic [WIDTH-1:0] prop;
    logic [NGRP:0]    gchain;
    logic [NGRP-1:0]  grp_cin;
    logic [NGRP-1:0]  grp_cout;
    logic [NGRP-1:0]  grp_skip;
    logic [NGRP-1:0]  grp_rip;

    csa_pg_gen #(.WIDTH(WIDTH)) u_pg (
        .op_a (a),
        .op_b (b),
        .gen  (gen),
        .prop (prop)
    );

    // The chain of group carries starts at the external carry-in.
    always_comb gchain[0] = cin;

    genvar k;
    generate
        for (k = 0; k < NGRP; k++) begin : g_grp
            csa_group #(.GRP(GRP)) u_grp (
                .gen      (gen[k*GRP +: GRP]),
                .prop     (prop[k*GRP +: GRP]),
                .c_in     (gchain[k]),
                .s        (sum[k*GRP +: GRP]),
                .c_ripple (grp_rip[k]),
                .skip     (grp_skip[k]),
                .c_out    (gchain[k+1])
            );
        end
    endgenerate

    // Group-boundary carries are made visible, and the final carry is taken out.
    always_comb begin
        grp_cin  = gchain[NGRP-1:0];
        grp_cout = gchain[NGRP:1];
        cout     = gchain[NGRP];
    end
endmodule

// File: rtl/carry_skip_adder_chk.sv
`timescale 1ns/1ps
// Module: carry_skip_adder_chk
// Checker bound into carry_skip_adder. Immediate assertions over the
// settled combinational values.
// Assumes: inputs carry no X and GRP divides WIDTH.
module carry_skip_adder_chk #(
    parameter int unsigned WIDTH = 16,
    parameter int unsigned GRP   = 4
) (
    input logic [WIDTH-1:0]      a,
    input logic [WIDTH-1:0]      b,
    input logic                  cin,
    input logic [WIDTH-1:0]      sum,
    input logic                  cout,
    input logic [WIDTH/GRP-1:0]  grp_cin,
    input logic [WIDTH/GRP-1:0]  grp_cout,
    input logic [WIDTH/GRP-1:0]  grp_skip,
    input logic [WIDTH/GRP-1:0]  grp_rip
);
    localparam int unsigned NGRP = WIDTH / GRP;

    // Word result and per-group carry selection.
    always_comb begin
        // R1
        sum_match_chk: assert ({cout, sum} == ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin}));
        if (&(a ^ b)) begin
            // R3
            all_prop_chk: assert ((cout == cin) && (sum == {WIDTH{~cin}}));
        end
        for (int k = 0; k < NGRP; k++) begin
            if (grp_skip[k]) begin
                // R4
                skip_pass_chk: assert (grp_cout[k] == grp_cin[k]);
            end else begin
                // R5
                ripple_sel_chk: assert (grp_cout[k] == grp_rip[k]);
            end
        end
    end
endmodule

bind carry_skip_adder carry_skip_adder_chk #(.WIDTH(WIDTH), .GRP(GRP)) u_chk (
    .a        (a),
    .b        (b),
    .cin      (cin),
    .sum      (sum),
    .cout     (cout),
    .grp_cin  (grp_cin),
    .grp_cout (grp_cout),
    .grp_skip (grp_skip),
    .grp_rip  (grp_rip)
);

// File: tb/carry_skip_adder_tb.sv
`timescale 1ns/1ps
// Bench: drives carry_skip_adder on the falling edge and compares it against
// a behavioural integer sum one nanosecond after each rising edge.
module carry_skip_adder_tb;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic [W-1:0] sum;
    logic         cout;
    int           checks = 0;
    int           fails = 0;
    bit           done = 1'b0;

    // 250 MHz clock.
    always #2 clk = ~clk;

    carry_skip_adder u_dut (
        .a    (a),
        .b    (b),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    // Applies one vector and compares against explicit expected values.
    task automatic apply_exp(input logic [W-1:0] ta, input logic [W-1:0] tb,
                             input logic tc, input logic [W-1:0] es,
                             input logic ec, input string tag);
        @(negedge clk);
        a = ta; b = tb; cin = tc;
        @(posedge clk);
        #1;
        checks++;
        if (sum !== es || cout !== ec) begin
            fails++;
            $display("FAIL %s: a=%h b=%h cin=%0b got sum=%h cout=%0b expected sum=%h cout=%0b",
                     tag, ta, tb, tc, sum, cout, es, ec);
        end
    endtask

    // Applies one vector with the expected result taken from integer arithmetic.
    task automatic apply_ref(input logic [W-1:0] ta, input logic [W-1:0] tb,
                             input logic tc, input string tag);
        int unsigned r;
        r = int'(ta) + int'(tb) + int'(tc);
        apply_exp(ta, tb, tc, r[W-1:0], r[W], tag);
    endtask

    // Watchdog: a hung run is counted as a failure.
    initial begin
        #(4 * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1 idle: all-zero inputs give zero.
        apply_exp(16'h0000, 16'h0000, 1'b0, 16'h0000, 1'b0, "R1 zero");
        // R2 carry out of the top bit.
        apply_exp(16'hFFFF, 16'h0001, 1'b0, 16'h0000, 1'b1, "R2 ffff+1");
        apply_exp(16'hFFFF, 16'h0001, 1'b1, 16'h0001, 1'b1, "R2 ffff+1+c");
        apply_exp(16'h7FFF, 16'h0001, 1'b0, 16'h8000, 1'b0, "R2 7fff+1");
        // R3 every bit propagating.
        apply_exp(16'hFFFF, 16'h0000, 1'b0, 16'hFFFF, 1'b0, "R3 ffff c0");
        apply_exp(16'hFFFF, 16'h0000, 1'b1, 16'h0000, 1'b1, "R3 ffff c1");
        apply_exp(16'hA5A5, 16'h5A5A, 1'b1, 16'h0000, 1'b1, "R3 a5a5 c1");
        for (int i = 0; i < 256; i++) begin
            logic [W-1:0] va;
            va = W'(i * 257);
            apply_exp(va, ~va, 1'b0, 16'hFFFF, 1'b0, "R3 sweep c0");
            apply_exp(va, ~va, 1'b1, 16'h0000, 1'b1, "R3 sweep c1");
        end
        // R4 a single skipping group passes a carry made below it.
        apply_exp(16'h00F8, 16'h0008, 1'b0, 16'h0100, 1'b0, "R4 grp1 skip");
        apply_exp(16'h0FF8, 16'h0008, 1'b0, 16'h1000, 1'b0, "R4 grp1-2 skip");
        apply_exp(16'h0F0F, 16'h0001, 1'b0, 16'h0F10, 1'b0, "R4 grp1 no carry");
        for (int k = 0; k < 4; k++) begin
            for (int c = 0; c < 2; c++) begin
                apply_ref(W'(16'h000F << (4 * k)) | 16'h0001, 16'h0001, c[0], "R4 per group");
            end
        end
        // R5 partly propagating groups use the rippled carry.
        apply_exp(16'h0007, 16'h0001, 1'b0, 16'h0008, 1'b0, "R5 ripple in grp0");
        apply_exp(16'h00E0, 16'h0020, 1'b0, 16'h0100, 1'b0, "R5 gen in grp1");
        // R6 carry from the lowest group across all higher groups.
        apply_exp(16'h0008, 16'hFFF8, 1'b0, 16'h0000, 1'b1, "R6 chain");
        apply_exp(16'h0000, 16'h0000, 1'b1, 16'h0001, 1'b0, "R6 cin only");
        // R7 subtraction via complement and carry-in.
        apply_exp(16'h0005, ~16'h0007, 1'b1, 16'hFFFE, 1'b0, "R7 5-7");
        apply_exp(16'h0007, ~16'h0005, 1'b1, 16'h0002, 1'b1, "R7 7-5");
        apply_exp(16'h1234, ~16'h1234, 1'b1, 16'h0000, 1'b1, "R7 x-x");
        for (int i = 0; i < 500; i++) begin
            logic [W-1:0] x;
            logic [W-1:0] y;
            logic [W-1:0] d;
            x = W'($urandom);
            y = W'($urandom);
            d = x - y;
            apply_exp(x, ~y, 1'b1, d, (x >= y), "R7 random sub");
        end
        // R1 R5 random vectors.
        for (int i = 0; i < 3000; i++) begin
            apply_ref(W'($urandom), W'($urandom), 1'($urandom), "R1 random");
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule